// File: doc/BRIEF.md
# Enclave Instruction Legality Checker

This block sits after instruction decode and decides whether an enclave-management or enclave-user instruction may execute. For each accepted request it looks at a decoded descriptor (leaf number and class, which prefixes are present, the processor's addressing mode, the protected-mode and paging flags, the data-segment attributes, the current privilege level, the code-segment mode and the enclave's 64-bit attribute). One cycle later it returns a verdict: proceed, undefined-opcode fault, or general-protection fault with a zero error code. Alongside the verdict it returns the effective address size that the instruction's memory operands will use.

Some prefixes are ignored and one faults. The address size comes only from the processor mode. The two debug read/write leaves are the only ones allowed to run with paging off. When several conditions fail at once, the undefined-opcode checks win over the data-segment check, and the entry-leaf checks come last. Requests arrive on a valid/ready channel and verdicts leave on another. The block holds one verdict. While that verdict waits for the consumer, new requests are refused, so back-pressure on the verdict side passes straight through to the request side.

Top module: `encl_legality_chk`

## Requirements
- R1: With protected mode off (`req_prot` = 0) every leaf of either class gets verdict 2'b01 (undefined-opcode fault). Verdict codes are 2'b00 proceed, 2'b01 undefined-opcode fault and 2'b10 general-protection fault.
- R2: Prefix bit 1 (operand size) yields 2'b01. Prefix bit 0 (segment override) and prefix bit 2 (address size) change neither the verdict nor the address size.
- R3: Mode codes are 2'b00 for 16-bit addressing, 2'b01 for 32-bit and 2'b10 for 64-bit. `rsp_addr64` is 1 in mode 2'b10 and 0 in modes 2'b00 and 2'b01, so 16-bit addressing still reports 32-bit operands.
- R4: With paging off (`req_paging` = 0) the verdict is 2'b01, except for the management-class (`req_user` = 0) debug leaves 4 and 5. A user-class leaf 4 or 5 is not exempt.
- R5: If no undefined-opcode condition holds, a data segment that is unusable or expand-down yields 2'b10.
- R6: The user-class (`req_user` = 1) entry leaves 2 and 3 yield 2'b10 when CPL is not 3 or `req_cs64` differs from `req_encl64`. All other leaves ignore CPL and the code-segment mode.
- R7: Any undefined-opcode condition takes priority over every general-protection condition.
- R8: Mode code 2'b11 is unsupported and yields 2'b01 with `rsp_addr64` = 0.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. A request accepted at a clock edge produces `rsp_valid` after that edge. While `rsp_ready` is low the verdict and address size stay valid and unchanged.
- R10: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_user | input | 1 | 1 = user-class leaf, 0 = management-class leaf |
| req_leaf | input | LEAF_W (8) | Leaf number |
| req_pfx | input | 3 | Prefixes present: bit0 segment override, bit1 operand size, bit2 address size |
| req_mode | input | 2 | Processor addressing mode |
| req_prot | input | 1 | Protected mode enabled |
| req_paging | input | 1 | Paging enabled |
| req_ds_usable | input | 1 | Data segment usable |
| req_ds_expdown | input | 1 | Data segment is expand-down |
| req_cpl | input | 2 | Current privilege level |
| req_cs64 | input | 1 | Code segment runs in 64-bit mode |
| req_encl64 | input | 1 | Enclave was created for 64-bit mode |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_verdict | output | 2 | Verdict code |
| rsp_addr64 | output | 1 | 1 = 64-bit operand addressing, 0 = 32-bit |

## Verification
The hardest case to reach from the ports is a verdict that must survive a stalled consumer while a different, conflicting request sits on the input. In that case the refusal through `req_ready` is the only thing that protects the stored result. The bench holds `rsp_ready` low after one accepted request. It then presents a second request whose verdict would differ, and checks that the first verdict is still there and that `req_ready` stays low. Fault-priority corners are reached with table vectors that make two or three conditions fail at once, for example an unusable data segment together with an operand-size prefix or with paging off.

// File: rtl/encl_chk_pkg.sv
package encl_chk_pkg;

  typedef enum logic [1:0] {
    VRD_OK = 2'b00,
    VRD_UD = 2'b01,
    VRD_GP = 2'b10
  } verdict_e;

  typedef enum logic [1:0] {
    MODE_A16 = 2'b00,
    MODE_A32 = 2'b01,
    MODE_A64 = 2'b10,
    MODE_BAD = 2'b11
  } mode_e;

  localparam int unsigned PFX_W      = 3;
  localparam int unsigned PFX_SEGOVR = 0;
  localparam int unsigned PFX_OPSZ   = 1;
  localparam int unsigned PFX_ADSZ   = 2;

  localparam int unsigned CPL_W      = 2;
  localparam logic [CPL_W-1:0] CPL_USER = 2'd3;

  typedef struct packed {
    verdict_e verdict;
    logic     addr64;
  } result_t;

  localparam int unsigned RESULT_W = $bits(result_t);

endpackage

// File: rtl/encl_leaf_decode.sv
module encl_leaf_decode #(
  parameter int unsigned LEAF_W     = 8,
  parameter int unsigned ENTER_LEAF = 2,
  parameter int unsigned RESUME_LEAF = 3,
  parameter int unsigned DBGRD_LEAF = 4,
  parameter int unsigned DBGWR_LEAF = 5
) (
  input  logic              user_cls,
  input  logic [LEAF_W-1:0] leaf,
  output logic              is_entry,
  output logic              is_debug
);

  localparam int unsigned NUM_CODES = 4;
  localparam logic [LEAF_W-1:0] CODES [NUM_CODES] = '{
    LEAF_W'(ENTER_LEAF), LEAF_W'(RESUME_LEAF),
    LEAF_W'(DBGRD_LEAF), LEAF_W'(DBGWR_LEAF)
  };

  logic [NUM_CODES-1:0] hit;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_match
    assign hit[g] = (leaf == CODES[g]);
  end

  assign is_entry = user_cls  & (hit[0] | hit[1]);
  assign is_debug = !user_cls & (hit[2] | hit[3]);

endmodule

// File: rtl/encl_fault_eval.sv
module encl_fault_eval
  import encl_chk_pkg::*;
#(
  parameter logic [PFX_W-1:0] PFX_FAULT_MASK = 3'b010
) (
  input  logic             is_entry,
  input  logic             is_debug,
  input  logic [PFX_W-1:0] pfx,
  input  mode_e            mode,
  input  logic             prot,
  input  logic             paging,
  input  logic             ds_usable,
  input  logic             ds_expdown,
  input  logic [CPL_W-1:0] cpl,
  input  logic             cs64,
  input  logic             encl64,
  output result_t          result
);

  logic [PFX_W-1:0] pfx_hit;
  logic ud_prot, ud_mode, ud_pfx, ud_paging, ud_any;
  logic gp_ds, gp_entry;

  for (genvar b = 0; b < PFX_W; b++) begin : g_pfx
    if (PFX_FAULT_MASK[b]) begin : g_fault
      assign pfx_hit[b] = pfx[b];
    end else begin : g_ignore
      assign pfx_hit[b] = 1'b0;
    end
  end

  assign ud_prot   = !prot;
  assign ud_mode   = (mode == MODE_BAD);
  assign ud_pfx    = |pfx_hit;
  assign ud_paging = !paging && !is_debug;
  assign ud_any    = ud_prot | ud_mode | ud_pfx | ud_paging;

  assign gp_ds     = !ds_usable || ds_expdown;
  assign gp_entry  = is_entry && ((cpl != CPL_USER) || (cs64 != encl64));

  always_comb begin
    result.addr64 = (mode == MODE_A64);
    if (ud_any)                result.verdict = VRD_UD;
    else if (gp_ds)            result.verdict = VRD_GP;
    else if (gp_entry)         result.verdict = VRD_GP;
    else                       result.verdict = VRD_OK;
  end

endmodule

// File: rtl/encl_rsp_stage.sv
module encl_rsp_stage #(
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/encl_legality_chk.sv
module encl_legality_chk
  import encl_chk_pkg::*;
#(
  parameter int unsigned LEAF_W      = 8,
  parameter int unsigned ENTER_LEAF  = 2,
  parameter int unsigned RESUME_LEAF = 3,
  parameter int unsigned DBGRD_LEAF  = 4,
  parameter int unsigned DBGWR_LEAF  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_user,
  input  logic [LEAF_W-1:0] req_leaf,
  input  logic [2:0]        req_pfx,
  input  logic [1:0]        req_mode,
  input  logic              req_prot,
  input  logic              req_paging,
  input  logic              req_ds_usable,
  input  logic              req_ds_expdown,
  input  logic [1:0]        req_cpl,
  input  logic              req_cs64,
  input  logic              req_encl64,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_verdict,
  output logic              rsp_addr64
);

  logic    is_entry, is_debug;
  result_t eval_res;
  result_t held_res;

  encl_leaf_decode #(
    .LEAF_W     (LEAF_W),
    .ENTER_LEAF (ENTER_LEAF),
    .RESUME_LEAF(RESUME_LEAF),
    .DBGRD_LEAF (DBGRD_LEAF),
    .DBGWR_LEAF (DBGWR_LEAF)
  ) i_dec (
    .user_cls(req_user),
    .leaf    (req_leaf),
    .is_entry(is_entry),
    .is_debug(is_debug)
  );

  encl_fault_eval i_eval (
    .is_entry  (is_entry),
    .is_debug  (is_debug),
    .pfx       (req_pfx),
    .mode      (mode_e'(req_mode)),
    .prot      (req_prot),
    .paging    (req_paging),
    .ds_usable (req_ds_usable),
    .ds_expdown(req_ds_expdown),
    .cpl       (req_cpl),
    .cs64      (req_cs64),
    .encl64    (req_encl64),
    .result    (eval_res)
  );

  encl_rsp_stage #(.DW(RESULT_W)) i_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (eval_res),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (held_res)
  );

  assign rsp_verdict = held_res.verdict;
  assign rsp_addr64  = held_res.addr64;

endmodule

// File: rtl/encl_legality_chk_sva.sv
module encl_legality_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_pfx,
  input logic [1:0] req_mode,
  input logic       req_prot,
  input logic       req_paging,
  input logic       req_ds_usable,
  input logic       req_ds_expdown,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_verdict,
  input logic       rsp_addr64
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_NO_PROT_UD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_prot |=> rsp_verdict == 2'b01); // R1

  AST_OPSZ_UD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_pfx[1] |=> rsp_verdict == 2'b01); // R2

  AST_ADDR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_addr64 == ($past(req_mode) == 2'b10)); // R3

  AST_DS_GP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_prot && req_paging && !req_pfx[1] && req_mode != 2'b11 &&
    (!req_ds_usable || req_ds_expdown) |=> rsp_verdict == 2'b10); // R5

  AST_BAD_MODE_UD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 2'b11 |=> rsp_verdict == 2'b01 && !rsp_addr64); // R8

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_verdict) && $stable(rsp_addr64)); // R9

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_verdict != 2'b11); // R7

endmodule

bind encl_legality_chk encl_legality_chk_sva i_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_pfx       (req_pfx),
  .req_mode      (req_mode),
  .req_prot      (req_prot),
  .req_paging    (req_paging),
  .req_ds_usable (req_ds_usable),
  .req_ds_expdown(req_ds_expdown),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_verdict   (rsp_verdict),
  .rsp_addr64    (rsp_addr64)
);

// File: tb/test_encl_legality_chk.sv
module test_encl_legality_chk;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_user = 1'b0;
  logic [7:0] req_leaf = '0;
  logic [2:0] req_pfx = '0;
  logic [1:0] req_mode = '0;
  logic       req_prot = 1'b0;
  logic       req_paging = 1'b0;
  logic       req_ds_usable = 1'b0;
  logic       req_ds_expdown = 1'b0;
  logic [1:0] req_cpl = '0;
  logic       req_cs64 = 1'b0;
  logic       req_encl64 = 1'b0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_verdict;
  logic       rsp_addr64;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  encl_legality_chk i_encl_legality_chk (.*);

  // Layout: req(4) user leaf(8) pfx(3) mode(2) prot pg use ed cpl(2) cs64 e64 verdict(2) a64
  localparam int NV = 23;
  localparam logic [28:0] VEC [NV] = '{
    29'b0110_1_00000010_000_10_1_1_1_0_11_1_1_00_1, // R6 clean entry
    29'b0010_1_00000010_001_10_1_1_1_0_11_1_1_00_1, // R2 seg override ignored
    29'b0010_1_00000010_100_10_1_1_1_0_11_1_1_00_1, // R2 addr size ignored
    29'b0010_1_00000010_010_10_1_1_1_0_11_1_1_01_1, // R2 operand size faults
    29'b0011_1_00000010_000_01_1_1_1_0_11_0_0_00_0, // R3 32-bit mode
    29'b0011_1_00000010_100_00_1_1_1_0_11_0_0_00_0, // R3 16-bit addr, prefix
    29'b0011_0_00000000_000_00_1_1_1_0_00_0_0_00_0, // R3 16-bit mgmt
    29'b0001_0_00000100_000_10_0_1_1_0_00_0_0_01_1, // R1 no protected mode
    29'b0100_0_00000100_000_10_1_0_1_0_00_0_0_00_1, // R4 debug read exempt
    29'b0100_0_00000101_000_01_1_0_1_0_00_0_0_00_0, // R4 debug write exempt
    29'b0100_0_00000000_000_10_1_0_1_0_00_0_0_01_1, // R4 other leaf faults
    29'b0100_1_00000100_000_10_1_0_1_0_11_1_1_01_1, // R4 user leaf 4 not exempt
    29'b0101_0_00000000_000_10_1_1_0_0_00_0_0_10_1, // R5 unusable
    29'b0101_0_00000001_000_01_1_1_1_1_00_0_0_10_0, // R5 expand-down
    29'b0111_0_00000000_010_10_1_1_0_0_00_0_0_01_1, // R7 opsize over ds
    29'b0111_0_00000001_000_10_1_0_1_1_00_0_0_01_1, // R7 paging over ds
    29'b0110_1_00000011_000_10_1_1_1_0_00_1_1_10_1, // R6 resume cpl 0
    29'b0110_1_00000010_000_10_1_1_1_0_11_0_1_10_1, // R6 cs mismatch
    29'b0110_1_00000001_000_10_1_1_1_0_00_0_1_00_1, // R6 non-entry user leaf
    29'b0110_0_00000010_000_10_1_1_1_0_00_0_1_00_1, // R6 mgmt leaf 2
    29'b1000_1_00000010_000_11_1_1_1_0_11_1_1_01_0, // R8 bad mode
    29'b0111_1_00000010_000_10_1_1_0_0_00_1_1_10_1, // R7 gp entry + ds
    29'b0001_0_00000100_000_10_0_0_1_0_00_0_0_01_1  // R1 no prot, debug leaf
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_vec(input logic [28:0] v);
    req_user       = v[24];
    req_leaf       = v[23:16];
    req_pfx        = v[15:13];
    req_mode       = v[12:11];
    req_prot       = v[10];
    req_paging     = v[9];
    req_ds_usable  = v[8];
    req_ds_expdown = v[7];
    req_cpl        = v[6:5];
    req_cs64       = v[4];
    req_encl64     = v[3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R10 req_ready after reset", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_vec(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R%0d vec %0d valid", VEC[i][28:25], i), int'(rsp_valid), 1);
      chk($sformatf("R%0d vec %0d verdict", VEC[i][28:25], i), int'(rsp_verdict), int'(VEC[i][2:1]));
      chk($sformatf("R%0d vec %0d addr64", VEC[i][28:25], i), int'(rsp_addr64), int'(VEC[i][0]));
    end

    @(negedge clk);
    chk("R9 valid drops when drained", int'(rsp_valid), 0);

    // R9 back-pressure: stall a GP verdict, offer a UD request meanwhile
    rsp_ready = 1'b0;
    load_vec(VEC[12]);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R9 stalled valid", int'(rsp_valid), 1);
    chk("R9 ready low while stalled", int'(req_ready), 0);
    load_vec(VEC[7]);
    @(negedge clk);
    chk("R9 verdict held", int'(rsp_verdict), 2);
    chk("R9 addr held", int'(rsp_addr64), 1);
    chk("R9 still valid", int'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued request after release", int'(rsp_verdict), 1);
    @(negedge clk);
    chk("R9 empty after drain", int'(rsp_valid), 0);

    // R10 reset mid-stream clears the held verdict
    rsp_ready = 1'b0;
    load_vec(VEC[0]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears valid", int'(rsp_valid), 0);
    chk("R10 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule